// File: doc/BRIEF.md
# Boundary-Scan Test Access Port with Instruction Decode

This block is the serial test port of a small device. A four-wire serial interface drives it: a test clock, a mode select, serial data in and serial data out, plus an optional asynchronous port reset. A sixteen-state controller follows the mode-select line on each rising edge of the test clock. A ten-bit instruction register picks which data register sits between serial-in and serial-out.

The data registers are a one-bit pass-through register, a 32-bit identification register, a 32-bit user code register and a boundary register of parameterised length. The boundary register samples the device pins and holds a pattern. In external-test mode it drives that pattern onto the pins in place of the core's functional outputs and enables every output driver. Serial output changes on the falling edge of the test clock. It comes with an output-enable that is high only while a register is being shifted. Designs without a port reset tie `trst_n` high and rely on five clocks with mode select high.

Top module: `tap_top`

## Requirements
- R1: The controller moves through the standard sixteen-state test sequence on each rising `tck` edge according to `tms`. Five consecutive rising edges with `tms` high reach Test-Logic-Reset from any state. `trst_n` low forces Test-Logic-Reset at once, without waiting for a clock edge.
- R2: In Test-Logic-Reset the active instruction becomes the identification opcode. Capture-IR loads 10'b00_0000_0001 into the instruction shift stage. Shift-IR takes `tdi` into the top bit and presents bit 0 on `tdo`. A shifted code becomes the active instruction only in Update-IR.
- R3: The opcodes are SAMPLE 10'h005, EXTEST 10'h00F, BYPASS 10'h3FF, USERCODE 10'h007 and IDCODE 10'h006. Every other code selects the one-bit pass-through register.
- R4: The pass-through register captures 0 in Capture-DR. In Shift-DR, each `tdi` bit appears on `tdo` one `tck` cycle later.
- R5: IDCODE selects a 32-bit register that captures the `IDCODE` parameter with bit 0 forced to 1 and shifts it out least significant bit first.
- R6: USERCODE selects a 32-bit register that captures the `USERCODE` parameter (all ones by default) and shifts it out least significant bit first.
- R7: Under SAMPLE, Capture-DR loads `pin_in` into the boundary shift stage, with bit 0 leaving first on `tdo`. Update-DR copies the shifted pattern into the update stage. Meanwhile `pin_out` follows `core_out` and `pin_oe` follows `core_oe`.
- R8: Under EXTEST, `test_mode` is 1, `pin_out` equals the update stage, `pin_oe` is all ones, and Capture-DR loads `pin_in`. Under any other instruction, `test_mode` is 0.
- R9: `tdo` and `tdo_oe` change only on the falling edge of `tck`. `tdo_oe` is 1 exactly while the controller is in Shift-IR or Shift-DR, and `tdo` is 0 whenever `tdo_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous port reset, active low (tie high if unused) |
| tms | input | 1 | Mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial data in, sampled on rising `tck` |
| pin_in | input | BSR_LEN | Values seen at the device pins |
| core_out | input | BSR_LEN | Functional output values from the core |
| core_oe | input | BSR_LEN | Functional output enables from the core |
| tdo | output | 1 | Serial data out, changes on falling `tck` |
| tdo_oe | output | 1 | Output-enable for `tdo` |
| pin_out | output | BSR_LEN | Values driven to the pins |
| pin_oe | output | BSR_LEN | Output enables driven to the pins |
| test_mode | output | 1 | High while EXTEST is the active instruction |

## Verification
A bit of a captured register appears on `tdo` at the falling edge that follows the rising edge that captured or shifted it. The bench therefore drives `tms` and `tdi` just after a falling edge and reads `tdo` shortly after the next falling edge. One directed step reads `tdo` between the rising and falling edges to show that the pin has not yet moved. Pin overrides and `test_mode` follow the rising edge that leaves Update-IR or Update-DR. They are read at the falling edge after that, and one read is taken partway through an instruction shift to show that the old instruction still holds. The port reset acts without a clock, so `test_mode` is read a few nanoseconds after `trst_n` falls.

// File: rtl/tap_pkg.sv
package tap_pkg;
  localparam int IR_W = 10;
  localparam int CODE_W = 32;

  localparam logic [IR_W-1:0] OP_SAMPLE  = 10'h005;
  localparam logic [IR_W-1:0] OP_EXTEST  = 10'h00F;
  localparam logic [IR_W-1:0] OP_BYPASS  = 10'h3FF;
  localparam logic [IR_W-1:0] OP_USER    = 10'h007;
  localparam logic [IR_W-1:0] OP_IDCODE  = 10'h006;
  localparam logic [IR_W-1:0] IR_CAPTURE = 10'h001;

  typedef enum logic [3:0] {
    ST_RESET, ST_IDLE,
    ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tap_state_e;

  typedef enum logic [1:0] {DR_BYP, DR_ID, DR_USER, DR_BSR} dr_sel_e;

  function automatic tap_state_e tap_next(tap_state_e s, logic tms);
    case (s)
      ST_RESET:  return tms ? ST_RESET  : ST_IDLE;
      ST_IDLE:   return tms ? ST_SEL_DR : ST_IDLE;
      ST_SEL_DR: return tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: return tms ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  return tms ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: return tms ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: return tms ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: return tms ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: return tms ? ST_SEL_DR : ST_IDLE;
      ST_SEL_IR: return tms ? ST_RESET  : ST_CAP_IR;
      ST_CAP_IR: return tms ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  return tms ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: return tms ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: return tms ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: return tms ? ST_UPD_IR : ST_SH_IR;
      default:   return tms ? ST_SEL_DR : ST_IDLE;
    endcase
  endfunction

  function automatic dr_sel_e ir_decode(logic [IR_W-1:0] op);
    case (op)
      OP_SAMPLE, OP_EXTEST: return DR_BSR;
      OP_IDCODE:            return DR_ID;
      OP_USER:              return DR_USER;
      default:              return DR_BYP;
    endcase
  endfunction

  function automatic logic [CODE_W-1:0] id_fix(logic [CODE_W-1:0] v);
    return {v[CODE_W-1:1], 1'b1};
  endfunction
endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
  import tap_pkg::*;
(
  input  logic       tck,
  input  logic       trst_n,
  input  logic       tms,
  output tap_state_e state
);
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) state <= ST_RESET;
    else         state <= tap_next(state, tms);
  end
endmodule

// File: rtl/tap_ir.sv
module tap_ir
  import tap_pkg::*;
(
  input  logic            tck,
  input  logic            trst_n,
  input  logic            in_reset,
  input  logic            cap_ir,
  input  logic            sh_ir,
  input  logic            up_ir,
  input  logic            tdi,
  output logic [IR_W-1:0] ir_sr,
  output logic [IR_W-1:0] ir
);
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      ir_sr <= IR_CAPTURE;
      ir    <= OP_IDCODE;
    end else begin
      if (cap_ir)     ir_sr <= IR_CAPTURE;
      else if (sh_ir) ir_sr <= {tdi, ir_sr[IR_W-1:1]};
      if (in_reset)   ir <= OP_IDCODE;
      else if (up_ir) ir <= ir_sr;
    end
  end
endmodule

// File: rtl/tap_dr.sv
module tap_dr
  import tap_pkg::*;
#(
  parameter int                BSR_LEN  = 8,
  parameter logic [CODE_W-1:0] IDCODE   = 32'h0000_0001,
  parameter logic [CODE_W-1:0] USERCODE = '1
) (
  input  logic               tck,
  input  logic               trst_n,
  input  logic               cap_dr,
  input  logic               sh_dr,
  input  logic               up_dr,
  input  dr_sel_e            dr_sel,
  input  logic               tdi,
  input  logic [BSR_LEN-1:0] pin_in,
  output logic               dr_so,
  output logic [BSR_LEN-1:0] upd
);
  localparam logic [CODE_W-1:0] ID_VAL = id_fix(IDCODE);

  logic              byp;
  logic [CODE_W-1:0] code_sr;
  logic [BSR_LEN-1:0] bsr_sr;
  logic sel_code, sel_bsr;

  assign sel_code = (dr_sel == DR_ID) || (dr_sel == DR_USER);
  assign sel_bsr  = (dr_sel == DR_BSR);

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      byp     <= 1'b0;
      code_sr <= '0;
    end else begin
      if (dr_sel == DR_BYP) begin
        if (cap_dr)     byp <= 1'b0;
        else if (sh_dr) byp <= tdi;
      end
      if (sel_code) begin
        if (cap_dr)     code_sr <= (dr_sel == DR_ID) ? ID_VAL : USERCODE;
        else if (sh_dr) code_sr <= {tdi, code_sr[CODE_W-1:1]};
      end
    end
  end

  for (genvar i = 0; i < BSR_LEN; i++) begin : g_cell
    logic shift_in;
    if (i == BSR_LEN - 1) begin : g_top
      assign shift_in = tdi;
    end else begin : g_mid
      assign shift_in = bsr_sr[i+1];
    end
    always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) begin
        bsr_sr[i] <= 1'b0;
        upd[i]    <= 1'b0;
      end else if (sel_bsr) begin
        if (cap_dr)     bsr_sr[i] <= pin_in[i];
        else if (sh_dr) bsr_sr[i] <= shift_in;
        if (up_dr)      upd[i] <= bsr_sr[i];
      end
    end
  end

  always_comb begin
    case (dr_sel)
      DR_BSR:         dr_so = bsr_sr[0];
      DR_ID, DR_USER: dr_so = code_sr[0];
      default:        dr_so = byp;
    endcase
  end
endmodule

// File: rtl/tap_top.sv
module tap_top
  import tap_pkg::*;
#(
  parameter int                BSR_LEN  = 8,
  parameter logic [CODE_W-1:0] IDCODE   = 32'h0000_0001,
  parameter logic [CODE_W-1:0] USERCODE = '1
) (
  input  logic               tck,
  input  logic               trst_n,
  input  logic               tms,
  input  logic               tdi,
  input  logic [BSR_LEN-1:0] pin_in,
  input  logic [BSR_LEN-1:0] core_out,
  input  logic [BSR_LEN-1:0] core_oe,
  output logic               tdo,
  output logic               tdo_oe,
  output logic [BSR_LEN-1:0] pin_out,
  output logic [BSR_LEN-1:0] pin_oe,
  output logic               test_mode
);
  tap_state_e      state;
  logic [IR_W-1:0] ir_sr, ir;
  dr_sel_e         dr_sel;
  logic            dr_so;
  logic [BSR_LEN-1:0] upd;

  logic in_reset, cap_ir, sh_ir, up_ir, cap_dr, sh_dr, up_dr;
  assign in_reset = (state == ST_RESET);
  assign cap_ir   = (state == ST_CAP_IR);
  assign sh_ir    = (state == ST_SH_IR);
  assign up_ir    = (state == ST_UPD_IR);
  assign cap_dr   = (state == ST_CAP_DR);
  assign sh_dr    = (state == ST_SH_DR);
  assign up_dr    = (state == ST_UPD_DR);

  assign dr_sel    = ir_decode(ir);
  assign test_mode = (ir == OP_EXTEST);

  tap_fsm u_fsm (.tck(tck), .trst_n(trst_n), .tms(tms), .state(state));

  tap_ir u_ir (
    .tck(tck), .trst_n(trst_n), .in_reset(in_reset), .cap_ir(cap_ir),
    .sh_ir(sh_ir), .up_ir(up_ir), .tdi(tdi), .ir_sr(ir_sr), .ir(ir)
  );

  tap_dr #(.BSR_LEN(BSR_LEN), .IDCODE(IDCODE), .USERCODE(USERCODE)) u_dr (
    .tck(tck), .trst_n(trst_n), .cap_dr(cap_dr), .sh_dr(sh_dr), .up_dr(up_dr),
    .dr_sel(dr_sel), .tdi(tdi), .pin_in(pin_in), .dr_so(dr_so), .upd(upd)
  );

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo_oe <= sh_ir | sh_dr;
      if (sh_ir)      tdo <= ir_sr[0];
      else if (sh_dr) tdo <= dr_so;
      else            tdo <= 1'b0;
    end
  end

  for (genvar i = 0; i < BSR_LEN; i++) begin : g_pin
    assign pin_out[i] = test_mode ? upd[i] : core_out[i];
    assign pin_oe[i]  = test_mode | core_oe[i];
  end
endmodule

// File: rtl/tap_top_chk.sv
module tap_top_chk
  import tap_pkg::*;
#(
  parameter int BSR_LEN = 8
) (
  input logic               tck,
  input logic               trst_n,
  input logic               tms,
  input tap_state_e         state,
  input logic [IR_W-1:0]    ir,
  input logic [IR_W-1:0]    ir_sr,
  input dr_sel_e            dr_sel,
  input logic               tdo,
  input logic               tdo_oe,
  input logic               test_mode,
  input logic [BSR_LEN-1:0] upd,
  input logic [BSR_LEN-1:0] core_out,
  input logic [BSR_LEN-1:0] core_oe,
  input logic [BSR_LEN-1:0] pin_out,
  input logic [BSR_LEN-1:0] pin_oe
);
  logic [2:0] hi_cnt;
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)            hi_cnt <= 3'd0;
    else if (!tms)          hi_cnt <= 3'd0;
    else if (hi_cnt != 3'd5) hi_cnt <= hi_cnt + 3'd1;
  end

  assert_tlr_after_five_R1: assert property (@(posedge tck) disable iff (!trst_n)
    (hi_cnt == 3'd5) |-> (state == ST_RESET));

  assert_ir_hold_R2: assert property (@(posedge tck) disable iff (!trst_n)
    (state != ST_UPD_IR && state != ST_RESET) |=> $stable(ir));

  assert_ir_capture_R2: assert property (@(posedge tck) disable iff (!trst_n)
    (state == ST_CAP_IR) |=> (ir_sr == IR_CAPTURE));

  assert_unknown_bypass_R3: assert property (@(posedge tck) disable iff (!trst_n)
    (ir != OP_SAMPLE && ir != OP_EXTEST && ir != OP_USER && ir != OP_IDCODE)
    |-> (dr_sel == DR_BYP));

  assert_functional_pass_R7: assert property (@(posedge tck) disable iff (!trst_n)
    !test_mode |-> (pin_out == core_out && pin_oe == core_oe));

  assert_extest_drive_R8: assert property (@(posedge tck) disable iff (!trst_n)
    test_mode |-> (pin_out == upd && pin_oe == {BSR_LEN{1'b1}}));

  assert_tdo_oe_R9: assert property (@(posedge tck) disable iff (!trst_n)
    tdo_oe == (state == ST_SH_IR || state == ST_SH_DR));

  assert_tdo_quiet_R9: assert property (@(posedge tck) disable iff (!trst_n)
    !tdo_oe |-> !tdo);
endmodule

bind tap_top tap_top_chk #(.BSR_LEN(BSR_LEN)) u_chk (
  .tck(tck), .trst_n(trst_n), .tms(tms), .state(state), .ir(ir), .ir_sr(ir_sr),
  .dr_sel(dr_sel), .tdo(tdo), .tdo_oe(tdo_oe), .test_mode(test_mode), .upd(upd),
  .core_out(core_out), .core_oe(core_oe), .pin_out(pin_out), .pin_oe(pin_oe)
);

// File: tb/tap_top_tb.sv
module tap_top_tb;
  localparam int N = 8;
  localparam logic [31:0] ID_RAW = 32'h0ABC_DEF0;

  logic tck, trst_n, tms, tdi;
  logic [N-1:0] pin_in, core_out, core_oe;
  logic tdo, tdo_oe, test_mode;
  logic [N-1:0] pin_out, pin_oe;

  int checks = 0, fails = 0, oe_bad = 0;
  logic mid_tm;
  logic [63:0] got, din;
  logic [9:0] irc;
  logic [N-1:0] pat;

  tap_top #(.BSR_LEN(N), .IDCODE(ID_RAW)) u_dut (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .pin_in(pin_in),
    .core_out(core_out), .core_oe(core_oe), .tdo(tdo), .tdo_oe(tdo_oe),
    .pin_out(pin_out), .pin_oe(pin_oe), .test_mode(test_mode)
  );

  initial tck = 1'b0;
  always #10 tck = ~tck;

  function automatic logic [31:0] exp_id(logic [31:0] raw);
    logic [31:0] r = raw;
    r[0] = 1'b1;
    return r;
  endfunction

  function automatic logic [63:0] exp_bypass(int n, logic [63:0] d);
    logic [63:0] r = '0;
    for (int i = 1; i < n; i++) r[i] = d[i-1];
    return r;
  endfunction

  function automatic logic is_listed(logic [9:0] c);
    return c == 10'h005 || c == 10'h00F || c == 10'h3FF || c == 10'h007 || c == 10'h006;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input logic m, input logic d);
    tms = m; tdi = d;
    @(posedge tck); @(negedge tck); #2;
  endtask

  task automatic shift_ir(input logic [9:0] code, output logic [9:0] cap);
    cap = '0;
    tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
    for (int i = 0; i < 10; i++) begin
      cap[i] = tdo;
      if (!tdo_oe) oe_bad++;
      if (i == 5) mid_tm = test_mode;
      tick(i == 9, code[i]);
    end
    tick(1, 0); tick(0, 0);
  endtask

  task automatic shift_dr(input int n, input logic [63:0] d, output logic [63:0] q);
    q = '0;
    tick(1, 0); tick(0, 0); tick(0, 0);
    for (int i = 0; i < n; i++) begin
      q[i] = tdo;
      if (!tdo_oe) oe_bad++;
      tick(i == n - 1, d[i]);
    end
    tick(1, 0); tick(0, 0);
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  endtask

  initial begin
    #4_000_000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    void'($urandom(32'd20240917));
    trst_n = 1'b0; tms = 1'b1; tdi = 1'b0;
    pin_in = '0;
    core_out = N'($urandom); core_oe = N'($urandom);
    #25 trst_n = 1'b1;
    @(negedge tck); #2;

    // reset state
    check("R9 reset tdo_oe", 64'(tdo_oe), 64'd0);
    check("R8 reset test_mode", 64'(test_mode), 64'd0);
    check("R7 reset pin_out", 64'(pin_out), 64'(core_out));
    check("R7 reset pin_oe", 64'(pin_oe), 64'(core_oe));

    // R2/R5: reset instruction is IDCODE
    tick(0, 0);
    shift_dr(32, 64'h0, got);
    check("R5 idcode after reset", got, 64'(exp_id(ID_RAW)));
    check("R9 idle tdo_oe", 64'(tdo_oe), 64'd0);

    // R2: IR capture pattern; R6 user code
    shift_ir(10'h007, irc);
    check("R2 ir capture", 64'(irc), 64'h001);
    shift_dr(32, 64'(32'h1234_5678), got);
    check("R6 usercode default", got, 64'hFFFF_FFFF);
    shift_dr(32, 64'h0, got);
    check("R6 usercode recaptured", got, 64'hFFFF_FFFF);

    // R3/R4: explicit bypass
    shift_ir(10'h3FF, irc);
    din = {$urandom, $urandom};
    shift_dr(40, din, got);
    check("R4 bypass delay", got, exp_bypass(40, din) & ((64'd1 << 40) - 1));

    // R3: unlisted codes select bypass
    for (int k = 0; k < 6; k++) begin
      logic [9:0] c;
      c = 10'($urandom);
      if (is_listed(c)) c = 10'h155;
      shift_ir(c, irc);
      din = 64'($urandom);
      shift_dr(20, din, got);
      check("R3 unlisted -> bypass", got, exp_bypass(20, din) & ((64'd1 << 20) - 1));
    end

    // R3: IDCODE opcode explicit
    shift_ir(10'h006, irc);
    shift_dr(32, 64'h0, got);
    check("R3 idcode opcode", got, 64'(exp_id(ID_RAW)));

    // R7/R8: sample then extest with several patterns
    for (int k = 0; k < 4; k++) begin
      shift_ir(10'h005, irc);
      pin_in = N'($urandom);
      core_out = N'($urandom); core_oe = N'($urandom);
      pat = N'($urandom);
      shift_dr(N, 64'(pat), got);
      check("R7 sample capture", got, 64'(pin_in));
      check("R7 sample pin_out functional", 64'(pin_out), 64'(core_out));
      check("R7 sample pin_oe functional", 64'(pin_oe), 64'(core_oe));
      shift_ir(10'h00F, irc);
      check("R2 old instruction mid-shift", 64'(mid_tm), 64'd0);
      check("R8 extest test_mode", 64'(test_mode), 64'd1);
      check("R8 extest pin_out preload", 64'(pin_out), 64'(pat));
      check("R8 extest pin_oe", 64'(pin_oe), {{(64-N){1'b0}}, {N{1'b1}}});
      pin_in = N'($urandom);
      pat = N'($urandom);
      shift_dr(N, 64'(pat), got);
      check("R8 extest capture", got, 64'(pin_in));
      check("R8 extest pin_out updated", 64'(pat), 64'(pin_out));
    end

    // R2: changing away from EXTEST holds until Update-IR
    shift_ir(10'h3FF, irc);
    check("R2 extest held mid-shift", 64'(mid_tm), 64'd1);
    check("R8 test_mode off", 64'(test_mode), 64'd0);
    check("R7 pin_out back", 64'(pin_out), 64'(core_out));

    // R9 / R4: falling-edge timing of tdo
    tick(1, 0); tick(0, 0); tick(0, 0);
    check("R4 bypass captured zero", 64'(tdo), 64'd0);
    tms = 1'b0; tdi = 1'b1;
    @(posedge tck); #2;
    check("R9 tdo stable after rising", 64'(tdo), 64'd0);
    @(negedge tck); #2;
    check("R9 tdo after falling", 64'(tdo), 64'd1);
    tick(1, 0);
    check("R9 exit tdo_oe", 64'(tdo_oe), 64'd0);
    check("R9 exit tdo", 64'(tdo), 64'd0);
    tick(1, 0); tick(0, 0);

    // R1: random walk then five ones
    shift_ir(10'h00F, irc);
    for (int k = 0; k < 23; k++) tick(1'($urandom), 1'($urandom));
    for (int k = 0; k < 5; k++) tick(1, 1'($urandom));
    check("R1 five ones test_mode", 64'(test_mode), 64'd0);
    tick(0, 0);
    shift_dr(32, 64'h0, got);
    check("R1 five ones -> idcode", got, 64'(exp_id(ID_RAW)));

    // R1: asynchronous port reset
    shift_ir(10'h00F, irc);
    check("R8 extest again", 64'(test_mode), 64'd1);
    trst_n = 1'b0; #3;
    check("R1 async reset test_mode", 64'(test_mode), 64'd0);
    #2 trst_n = 1'b1;
    @(negedge tck); #2;
    tick(0, 0);
    shift_dr(32, 64'h0, got);
    check("R1 async reset -> idcode", got, 64'(exp_id(ID_RAW)));

    check("R9 tdo_oe during shifts", 64'(oe_bad), 64'd0);
    summary();
  end
endmodule